// File: doc/BRIEF.md
# Negative Temporal Relation Observer

This block watches two state-active levels and one event pulse on the system clock. It raises a flag when a forbidden combination of states and events appears. A mode input picks one of four negative relations:

- the state is active when the event fires;
- the two states overlap, checked from both sides;
- the second state appears after the first state has ended;
- the first state appears after the event has fired.

Each state is treated as a closed interval. The interval runs from the cycle its level first reads high to the first cycle its level reads low again, and both of those end cycles count as inside.

The observer is a negative scenario. It has no success outcome and only records that an error condition was entered. An internal machine has three states. QUIET means nothing is armed. ARMED means a forbid relation has seen its reference point. TRIPPED means a violation was seen, and this state is left only through reset. The named transitions are:

- `arm`: QUIET to ARMED, when the reference point of a forbid mode is seen;
- `disarm`: ARMED to QUIET, on the clear input or a mode change;
- `hit`: QUIET to TRIPPED, on an exclusion violation;
- `forbid_hit`: ARMED to TRIPPED, when the forbidden state is active;
- `hold`: TRIPPED to TRIPPED, with no exit.

The sticky output follows TRIPPED. A companion pulse marks the first cycle of TRIPPED.

Top module: `neg_relation_observer`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs read 0 after that edge, the machine returns to QUIET and both previous-level registers clear to 0.
- R2: In mode 2'b00, `event_p` high in a cycle where `state_a` is high, or where `state_a` is low but was high in the previous cycle (the end cycle), trips the observer.
- R3: In mode 2'b00, `event_p` in a cycle where `state_a` is low and was also low in the previous cycle has no effect on the outputs.
- R4: In mode 2'b01, a start of B (`state_b` high while it was low in the previous cycle) while A is inside its interval trips the observer. The same holds with the roles of A and B swapped.
- R5: In mode 2'b01, a start of B in A's end cycle trips the observer. A start of B one cycle after A's end cycle does not.
- R6: In mode 2'b10, the end cycle of A arms the observer. From the next cycle on, `state_b` high trips it. `state_b` high during the end cycle itself does not trip it.
- R7: In mode 2'b11, `event_p` arms the observer. From the next cycle on, `state_a` high trips it. `state_a` high in the event cycle itself does not trip it.
- R8: `clear_arm` disarms, and it takes precedence over both arming and a forbid hit in the same cycle. A change of `mode` while armed also disarms in the following cycle.
- R9: `viol_sticky` stays high until reset. `viol_pulse` is high for exactly one cycle, which is the first cycle in which `viol_sticky` reads high.
- R10: A violation shows up on the outputs after the rising edge that samples it, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Relation select: 00 excl-event, 01 excl-state, 10 forbid-after-A, 11 forbid-after-event |
| state_a | input | 1 | Level, high while state A is active |
| state_b | input | 1 | Level, high while state B is active |
| event_p | input | 1 | Event pulse, one cycle per occurrence |
| clear_arm | input | 1 | Disarms the forbid modes |
| viol_sticky | output | 1 | High from the first violation until reset |
| viol_pulse | output | 1 | One-cycle marker of the first violation |

## Verification
The bench builds the block with the package defaults: two tracked levels and a two-bit mode. With these values all four mode codes can be reached, and so can every machine transition, including `disarm` by mode change. Randomized runs with sparse level toggles reach the end-cycle overlaps and the same-cycle clear races. These cases decide whether an interval end is inclusive.

// File: rtl/nro_pkg.sv
package nro_pkg;
    localparam int MODE_W = 2;
    localparam int NUM_LVL = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_EXCL_EVT   = 2'b00,
        MODE_EXCL_ST    = 2'b01,
        MODE_FORBID_ST  = 2'b10,
        MODE_FORBID_EVT = 2'b11
    } nro_mode_e;

    typedef enum logic [1:0] {
        OBS_QUIET   = 2'b00,
        OBS_ARMED   = 2'b01,
        OBS_TRIPPED = 2'b10
    } obs_state_e;
endpackage

// File: rtl/nro_edges.sv
module nro_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev[i];
    end
endmodule

// File: rtl/nro_rules.sv
module nro_rules
    import nro_pkg::*;
(
    input  nro_mode_e          mode,
    input  logic [NUM_LVL-1:0] lvl,
    input  logic [NUM_LVL-1:0] prev,
    input  logic [NUM_LVL-1:0] rise,
    input  logic               evt,
    output logic               hit_now,
    output logic               arm_evt,
    output logic               forbid_lvl
);
    logic in_a, in_b, end_a;

    // closed interval: the first low cycle after a high one still belongs
    assign in_a  = lvl[IDX_A] | prev[IDX_A];
    assign in_b  = lvl[IDX_B] | prev[IDX_B];
    assign end_a = prev[IDX_A] & ~lvl[IDX_A];

    always_comb begin
        hit_now    = 1'b0;
        arm_evt    = 1'b0;
        forbid_lvl = 1'b0;
        unique case (mode)
            MODE_EXCL_EVT: begin
                hit_now = evt & in_a;
            end
            MODE_EXCL_ST: begin
                hit_now = (rise[IDX_B] & in_a) | (rise[IDX_A] & in_b);
            end
            MODE_FORBID_ST: begin
                arm_evt    = end_a;
                forbid_lvl = lvl[IDX_B];
            end
            MODE_FORBID_EVT: begin
                arm_evt    = evt;
                forbid_lvl = lvl[IDX_A];
            end
        endcase
    end
endmodule

// File: rtl/neg_relation_observer.sv
module neg_relation_observer
    import nro_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       state_a,
    input  logic       state_b,
    input  logic       event_p,
    input  logic       clear_arm,
    output logic       viol_sticky,
    output logic       viol_pulse
);
    logic [NUM_LVL-1:0] lvl, prev, rise;
    logic               hit_now, arm_evt, forbid_lvl;
    nro_mode_e          mode_e, mode_q;
    obs_state_e         state_q, state_d;

    assign lvl[IDX_A] = state_a;
    assign lvl[IDX_B] = state_b;
    assign mode_e     = nro_mode_e'(mode);

    nro_edges #(.N(NUM_LVL)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .prev (prev),
        .rise (rise)
    );

    nro_rules u_rules (
        .mode       (mode_e),
        .lvl        (lvl),
        .prev       (prev),
        .rise       (rise),
        .evt        (event_p),
        .hit_now    (hit_now),
        .arm_evt    (arm_evt),
        .forbid_lvl (forbid_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_EXCL_EVT;
        else     mode_q <= mode_e;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OBS_QUIET;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OBS_QUIET: begin
                if (hit_now)                     state_d = OBS_TRIPPED;
                else if (arm_evt && !clear_arm)  state_d = OBS_ARMED;
            end
            OBS_ARMED: begin
                if (clear_arm || mode_e != mode_q) state_d = OBS_QUIET;
                else if (forbid_lvl)               state_d = OBS_TRIPPED;
            end
            OBS_TRIPPED: state_d = OBS_TRIPPED;
            default:     state_d = OBS_QUIET;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            viol_sticky <= 1'b0;
            viol_pulse  <= 1'b0;
        end else begin
            viol_sticky <= (state_d == OBS_TRIPPED);
            viol_pulse  <= (state_d == OBS_TRIPPED) && (state_q != OBS_TRIPPED);
        end
    end
endmodule

// File: rtl/nro_checker.sv
module nro_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       state_a,
    input logic       state_b,
    input logic       event_p,
    input logic       viol_sticky,
    input logic       viol_pulse
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!viol_sticky && !viol_pulse));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        viol_sticky |=> viol_sticky);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |=> !viol_pulse);

    // R9
    pulse_first_chk: assert property (@(posedge clk) disable iff (rst)
        (live && viol_pulse) |-> (viol_sticky && !$past(viol_sticky)));

    // R2
    excl_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 2'b00 && $past(mode) == 2'b00 && event_p && state_a) |=> viol_sticky);

    // R4
    excl_st_chk: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 2'b01 && $past(mode) == 2'b01 && state_a && state_b && !$past(state_b))
        |=> viol_sticky);
endmodule

bind neg_relation_observer nro_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .state_a     (state_a),
    .state_b     (state_b),
    .event_p     (event_p),
    .viol_sticky (viol_sticky),
    .viol_pulse  (viol_pulse)
);

// File: tb/sim_neg_relation_observer.sv
module sim_neg_relation_observer;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       state_a, state_b, event_p, clear_arm;
    logic       viol_sticky, viol_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench reference state
    logic m_pa, m_pb, m_armed, m_trip, m_pulse;
    logic [1:0] m_mq;

    always #5 clk = ~clk;

    neg_relation_observer u0 (
        .clk(clk), .rst(rst), .mode(mode), .state_a(state_a), .state_b(state_b),
        .event_p(event_p), .clear_arm(clear_arm),
        .viol_sticky(viol_sticky), .viol_pulse(viol_pulse)
    );

    function automatic string tag_of(input logic [1:0] md);
        case (md)
            2'b00:   return "R2";
            2'b01:   return "R4";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_step();
        logic in_a, in_b, ra, rb, fa, hit, arm, forb, nt;
        if (rst) begin
            m_pa = 0; m_pb = 0; m_armed = 0; m_trip = 0; m_pulse = 0; m_mq = 0;
            return;
        end
        in_a = state_a | m_pa;   in_b = state_b | m_pb;
        ra   = state_a & !m_pa;  rb   = state_b & !m_pb;
        fa   = m_pa & !state_a;
        hit  = (mode == 2'b00 && event_p && in_a) ||
               (mode == 2'b01 && ((rb && in_a) || (ra && in_b)));
        arm  = (mode == 2'b10 && fa) || (mode == 2'b11 && event_p);
        forb = (mode == 2'b10) ? state_b : ((mode == 2'b11) ? state_a : 1'b0);
        nt = m_trip;
        if (!m_trip) begin
            if (!m_armed) begin
                if (hit) nt = 1;
                else if (arm && !clear_arm) m_armed = 1;
            end else begin
                if (clear_arm || mode != m_mq) m_armed = 0;
                else if (forb) nt = 1;
            end
        end
        m_pulse = nt && !m_trip;
        m_trip  = nt;
        m_pa = state_a; m_pb = state_b; m_mq = mode;
    endtask

    task automatic tick(input logic a, input logic b, input logic e, input logic c);
        state_a = a; state_b = b; event_p = e; clear_arm = c;
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] md);
        mode = md;
        rst = 1;
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        rst = 0;
    endtask

    task automatic chk(input string tag, input logic es, input logic ep);
        checks++;
        if (viol_sticky !== es || viol_pulse !== ep) begin
            fails++;
            $display("FAIL %s: sticky/pulse actual %b%b expected %b%b at %0t",
                     tag, viol_sticky, viol_pulse, es, ep, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; mode = 0; state_a = 0; state_b = 0; event_p = 0; clear_arm = 0;
        @(negedge clk);

        // R1 reset state
        do_reset(2'b00);
        chk("R1", 0, 0);

        // R2 event inside A, R10 no same-cycle response, R9 pulse/sticky shape
        do_reset(2'b00);
        tick(1, 0, 0, 0);
        state_a = 1; event_p = 1; model_step();
        #1 chk("R10", 0, 0);
        @(negedge clk);
        chk("R2", 1, 1);
        tick(1, 0, 0, 0); chk("R9", 1, 0);
        tick(0, 0, 0, 0); tick(0, 0, 1, 0); tick(0, 0, 0, 0);
        chk("R9", 1, 0);

        // R2 end cycle inclusive
        do_reset(2'b00);
        tick(1, 0, 0, 0);
        tick(0, 0, 1, 0); chk("R2", 1, 1);

        // R3 event outside the interval
        do_reset(2'b00);
        tick(0, 0, 1, 0); chk("R3", 0, 0);
        tick(1, 0, 0, 0); tick(0, 0, 0, 0);
        tick(0, 0, 1, 0); chk("R3", 0, 0);

        // R5 B starts one cycle after A's end cycle: no trip
        do_reset(2'b01);
        tick(1, 0, 0, 0); tick(1, 0, 0, 0); tick(0, 0, 0, 0);
        tick(0, 1, 0, 0); chk("R5", 0, 0);
        // R5 B starts in A's end cycle: trip
        do_reset(2'b01);
        tick(1, 0, 0, 0);
        tick(0, 1, 0, 0); chk("R5", 1, 1);

        // R4 A starts while B active
        do_reset(2'b01);
        tick(0, 1, 0, 0);
        tick(1, 1, 0, 0); chk("R4", 1, 1);

        // R6 forbid B after A ends
        do_reset(2'b10);
        tick(1, 0, 0, 0);
        tick(0, 1, 0, 0); chk("R6", 0, 0);
        tick(0, 0, 0, 0); chk("R6", 0, 0);
        tick(0, 1, 0, 0); chk("R6", 1, 1);

        // R7 forbid A after event
        do_reset(2'b11);
        tick(1, 0, 1, 0); chk("R7", 0, 0);
        tick(0, 0, 0, 0); chk("R7", 0, 0);
        tick(1, 0, 0, 0); chk("R7", 1, 1);

        // R8 clear disarms
        do_reset(2'b11);
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 1);
        tick(1, 0, 0, 0); chk("R8", 0, 0);
        // R8 clear beats arming in the same cycle
        do_reset(2'b11);
        tick(0, 0, 1, 1);
        tick(1, 0, 0, 0); chk("R8", 0, 0);
        // R8 clear beats a forbid hit in the same cycle
        do_reset(2'b11);
        tick(0, 0, 1, 0);
        tick(1, 0, 0, 1); chk("R8", 0, 0);
        // R8 mode change disarms
        do_reset(2'b11);
        tick(0, 0, 1, 0);
        mode = 2'b00;
        tick(0, 0, 0, 0);
        mode = 2'b11;
        tick(1, 0, 0, 0); chk("R8", 0, 0);

        // randomized runs against the bench reference
        for (int t = 0; t < 150; t++) begin
            do_reset(2'($urandom_range(3)));
            chk("R1", 0, 0);
            for (int k = 0; k < 40; k++) begin
                logic na, nb, ne, nc;
                na = ($urandom_range(3) == 0) ? !state_a : state_a;
                nb = ($urandom_range(3) == 0) ? !state_b : state_b;
                ne = ($urandom_range(7) == 0);
                nc = ($urandom_range(15) == 0);
                if ($urandom_range(31) == 0) mode = 2'($urandom_range(3));
                tick(na, nb, ne, nc);
                chk(tag_of(mode), m_trip, m_pulse);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule